// File: doc/BRIEF.md
# Target Read Data Phase Pacer

This block paces the data phases of a bus target while it answers a read. It sits between the read data FIFO, which the application fills, and the target handshake logic. It decides in each clock cycle whether to drive target-ready and pop one FIFO word, whether to insert a wait state, or whether to ask the handshake logic to disconnect. The handshake logic raises `rd_active` for as long as a read transfer is in progress and drops it when the transfer ends.

The application has two controls. `hold_req` keeps the first data phase from starting. It takes effect until the application releases it or the FIFO fills. `burst_pend_n` is active low. It chooses what happens when the FIFO runs dry in the middle of a transfer. When asserted, the block waits a bounded number of cycles for a refill. When deasserted, it disconnects at once. If `dly_rd_en` is low, the block treats `burst_pend_n` as asserted. The block also reports when either control is asserted for less than the required minimum number of cycles.

The whole block runs in one bus clock domain. It has a synchronous active-low reset.

Top module: `rd_phase_pacer`

## Requirements
- R1: While `rst_n` is low, `trdy`, `fifo_pop`, `disc_req`, `proto_err` and `wait_cnt` are all zero, even if a transfer is being requested. After reset is released, no data phase starts until `rd_active` is high.
- R2: A transfer that starts while `hold_req` is high keeps `trdy` low for as long as `hold_req` stays high and the FIFO is not full. `trdy` first rises in the cycle that follows the clock edge at which `hold_req` is sampled low with data present.
- R3: While `hold_req` stays high, the FIFO becoming full (`fifo_full` high, or `fifo_level` equal to FIFO_DEPTH) releases the first data phase. `trdy` rises in the cycle after the edge at which full is sampled.
- R4: Once data phases have started, `hold_req` has no effect. A FIFO holding N words gives N consecutive `trdy` cycles while `hold_req` stays high.
- R5: `trdy` is high only in cycles where the FIFO is non-empty (`fifo_empty` low and `fifo_level` non-zero). `fifo_pop` equals `trdy`, so each `trdy` cycle removes exactly one word.
- R6: In burst mode (`burst_pend_n` low), each cycle of the transfer with an empty FIFO increments `wait_cnt` by one. A completed data phase clears `wait_cnt` to 0 by the next cycle. A refill within the limit resumes `trdy` without a disconnect.
- R7: In burst mode, after MAX_WAIT (8) consecutive empty cycles, `wait_cnt` holds at 8. `disc_req` rises in the same cycle that `wait_cnt` reaches 8.
- R8: With `burst_pend_n` high and `dly_rd_en` high, the first empty cycle of a transfer raises `disc_req` in the following cycle, with `wait_cnt` left at 0.
- R9: With `dly_rd_en` low, a high `burst_pend_n` is ignored and the block uses burst mode: it waits, counts, and disconnects only after 8 empty cycles.
- R10: `disc_req` stays high while `rd_active` is high, and `trdy` stays low, even if new data arrives. `trdy` and `disc_req` are never high together. The cycle after `rd_active` is sampled low, both are low.
- R11: Every new transfer applies the hold check again, even when data is already waiting in the FIFO.
- R12: `proto_err[0]` (for `hold_req`) and `proto_err[1]` (for `burst_pend_n` asserted low) go high in the cycle in which the control is deasserted after being asserted for fewer than MIN_ASSERT (2) clock edges. An assertion of two or more edges raises no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_active | input | 1 | High while a read transfer is in progress |
| hold_req | input | 1 | Application request to delay the first data phase |
| burst_pend_n | input | 1 | Active low: wait for refill instead of disconnecting |
| dly_rd_en | input | 1 | When low, burst mode is forced |
| fifo_full | input | 1 | Read FIFO full |
| fifo_empty | input | 1 | Read FIFO empty |
| fifo_level | input | $clog2(FIFO_DEPTH+1) | Read FIFO word count |
| trdy | output | 1 | Target ready, data phase in this cycle |
| fifo_pop | output | 1 | Remove one word from the read FIFO |
| disc_req | output | 1 | Disconnect request to the handshake logic |
| wait_cnt | output | $clog2(MAX_WAIT+1) | Consecutive wait states in the current gap |
| proto_err | output | 2 | Short-assertion flags: bit 0 hold, bit 1 burst pending |

## Verification
The bound checker tests several properties on every cycle:
- `trdy` is only raised over a non-empty FIFO, and it pops the FIFO;
- `trdy` and `disc_req` are never high together;
- `wait_cnt` never exceeds its limit and clears after a data phase;
- a disconnect stays asserted until the transfer ends, and the outputs go quiet afterwards;
- outputs are silent in reset;
- a short-assertion flag appears only on a deassertion edge.

Some behaviours need a sequence of stimulus and can only be shown by the bench's scenarios: how long the hold check delays the first data phase, release on a full FIFO, the exact cycle of the immediate disconnect compared with the eight-cycle timeout, burst mode forced by `dly_rd_en`, and the hold check applied again on a new transfer.

// File: rtl/pacer_pkg.sv
// Shared types for the read data phase pacer.
package pacer_pkg;

    // Phase of one read transfer as seen by the pacer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no transfer in progress
        ST_HOLD = 2'd1,   // transfer open, first data phase held back
        ST_XFER = 2'd2,   // data phases running, wait states allowed
        ST_DISC = 2'd3    // disconnect requested, waiting for transfer end
    } pacer_st_e;

endpackage

// File: rtl/pacer_pulse_mon.sv
// Minimum-assertion monitor for one active-high control.
// It counts consecutive asserted clock edges, saturating at MIN_ASSERT.
// If the control drops while the count is non-zero and below MIN_ASSERT,
// short_pulse is high in that same (deassert) cycle.
// Assumes: sig_on is synchronous to clk.
module pacer_pulse_mon #(
    parameter int MIN_ASSERT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_on,
    output logic short_pulse
);
    localparam int CW = $clog2(MIN_ASSERT + 1);
    localparam logic [CW-1:0] MIN_C = CW'(MIN_ASSERT);

    logic [CW-1:0] run_q;

    // Count consecutive asserted edges; clear on deassertion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!sig_on) begin
            run_q <= '0;
        end else if (run_q < MIN_C) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Flag a deassertion that came too early.
    always_comb begin
        short_pulse = rst_n && !sig_on && (run_q != '0) && (run_q < MIN_C);
    end

endmodule

// File: rtl/pacer_wait_ctr.sv
// Wait-state counter for gaps between data phases.
// Clear has priority over increment. The count saturates at MAX_WAIT.
// at_last is high when one more wait state would reach the limit.
// Assumes: clr and inc are computed in the same clock domain.
module pacer_wait_ctr #(
    parameter int MAX_WAIT = 8,
    localparam int CW = $clog2(MAX_WAIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count,
    output logic          at_last
);
    localparam logic [CW-1:0] MAX_C  = CW'(MAX_WAIT);
    localparam logic [CW-1:0] LAST_C = CW'(MAX_WAIT - 1);

    logic [CW-1:0] cnt_q;

    // Counter register with clear priority and saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != MAX_C)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expose the count and the one-before-limit decode.
    always_comb begin
        count   = cnt_q;
        at_last = (cnt_q == LAST_C);
    end

endmodule

// File: rtl/pacer_fsm.sv
// Transfer phase controller for the read pacer.
// Moves IDLE -> HOLD when a transfer opens, HOLD -> XFER when the start
// condition is met, and XFER -> DISC on an immediate or timed-out
// disconnect. Any state returns to IDLE when the transfer closes.
// Assumes: all inputs synchronous; start_ok already combines the hold
// release and the FIFO-full override.
module pacer_fsm
    import pacer_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rd_active,
    input  logic      start_ok,
    input  logic      fifo_dry,
    input  logic      burst_mode,
    input  logic      wait_last,
    output pacer_st_e state
);
    pacer_st_e st_q, st_d;

    // Next-state decision for one transfer.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (rd_active) st_d = ST_HOLD;
            ST_HOLD: begin
                if (!rd_active)    st_d = ST_IDLE;
                else if (start_ok) st_d = ST_XFER;
            end
            ST_XFER: begin
                if (!rd_active) begin
                    st_d = ST_IDLE;
                end else if (fifo_dry) begin
                    if (!burst_mode)    st_d = ST_DISC;
                    else if (wait_last) st_d = ST_DISC;
                end
            end
            ST_DISC: if (!rd_active) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register, forced to idle in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Drive the current state out to the datapath.
    always_comb begin
        state = st_q;
    end

endmodule

// File: rtl/rd_phase_pacer.sv
// Target read data phase pacer (top).
// Decides each cycle between a data phase (trdy + FIFO pop), a wait
// state and a disconnect request during a read transfer. It also monitors
// the minimum assertion length of the application's controls.
// Assumes: single clock domain, synchronous active-low reset, and the
// FIFO status inputs describe the FIFO before this cycle's pop.
module rd_phase_pacer
    import pacer_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int MAX_WAIT   = 8,
    parameter int MIN_ASSERT = 2,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
    localparam int WAIT_W    = $clog2(MAX_WAIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_active,
    input  logic              hold_req,
    input  logic              burst_pend_n,
    input  logic              dly_rd_en,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    input  logic [LVL_W-1:0]  fifo_level,
    output logic              trdy,
    output logic              fifo_pop,
    output logic              disc_req,
    output logic [WAIT_W-1:0] wait_cnt,
    output logic [1:0]        proto_err
);
    localparam int NUM_CTRL = 2;
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

    pacer_st_e          state;
    logic               fifo_dry;
    logic               fifo_topped;
    logic               burst_mode;
    logic               start_ok;
    logic               ctr_clr;
    logic               ctr_inc;
    logic               wait_last;
    logic [WAIT_W-1:0]  ctr_val;
    logic [NUM_CTRL-1:0] ctrl_on;
    logic [NUM_CTRL-1:0] short_flag;

    // Combine the FIFO flags and the count into one empty and one full view.
    always_comb begin
        fifo_dry    = fifo_empty || (fifo_level == '0);
        fifo_topped = fifo_full  || (fifo_level == FULL_LVL);
    end

    // Choose the mode and the start condition from the application controls.
    always_comb begin
        burst_mode = !burst_pend_n || !dly_rd_en;
        start_ok   = !hold_req || fifo_topped;
    end

    pacer_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_active  (rd_active),
        .start_ok   (start_ok),
        .fifo_dry   (fifo_dry),
        .burst_mode (burst_mode),
        .wait_last  (wait_last),
        .state      (state)
    );

    // Data phase: ready only when running and a word is available.
    always_comb begin
        trdy     = rst_n && (state == ST_XFER) && !fifo_dry;
        fifo_pop = trdy;
        disc_req = rst_n && (state == ST_DISC);
    end

    // Count empty cycles while running in burst mode; clear on a data
    // phase or outside a running transfer.
    always_comb begin
        ctr_clr = (state == ST_IDLE) || (state == ST_HOLD) || trdy;
        ctr_inc = (state == ST_XFER) && fifo_dry && burst_mode;
    end

    pacer_wait_ctr #(
        .MAX_WAIT (MAX_WAIT)
    ) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctr_clr),
        .inc     (ctr_inc),
        .count   (ctr_val),
        .at_last (wait_last)
    );

    // Gate the observed count in reset.
    always_comb begin
        wait_cnt = rst_n ? ctr_val : '0;
    end

    // Normalise the controls to active-high for the monitors.
    always_comb begin
        ctrl_on[0] = hold_req;
        ctrl_on[1] = !burst_pend_n;
    end

    // One minimum-assertion monitor per application control.
    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_mon
        pacer_pulse_mon #(
            .MIN_ASSERT (MIN_ASSERT)
        ) u_mon (
            .clk         (clk),
            .rst_n       (rst_n),
            .sig_on      (ctrl_on[g]),
            .short_pulse (short_flag[g])
        );
    end

    // Drive the violation flags out.
    always_comb begin
        proto_err = short_flag;
    end

endmodule

// File: rtl/pacer_chk.sv
// Property checker for the read data phase pacer, bound to the top.
// Watches only the top's ports.
module pacer_chk #(
    parameter int MAX_WAIT = 8,
    parameter int WCW      = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rd_active,
    input logic           hold_req,
    input logic           burst_pend_n,
    input logic           fifo_empty,
    input logic           trdy,
    input logic           fifo_pop,
    input logic           disc_req,
    input logic [WCW-1:0] wait_cnt,
    input logic [1:0]     proto_err
);
    // R1: quiet outputs in reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!trdy && !disc_req && !fifo_pop && (wait_cnt == '0) && (proto_err == 2'b00)));

    // R5: ready only over data, one pop per ready
    assert_trdy_has_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trdy |-> !fifo_empty);
    assert_pop_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop == trdy);

    // R6: a completed data phase clears the count
    assert_wait_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trdy |=> (wait_cnt == '0));

    // R7: count never passes the limit
    assert_wait_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= WCW'(MAX_WAIT));

    // R10: disconnect held, exclusive with ready, dropped after transfer end
    assert_disc_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (disc_req && rd_active) |=> disc_req);
    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(trdy && disc_req));
    assert_end_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_active |=> (!trdy && !disc_req));

    // R12: flags only on a deassertion edge of the control
    assert_hold_flag_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err[0] |-> (!hold_req && $past(hold_req)));
    assert_burst_flag_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err[1] |-> (burst_pend_n && !$past(burst_pend_n)));

endmodule

bind rd_phase_pacer pacer_chk #(
    .MAX_WAIT (MAX_WAIT),
    .WCW      (WAIT_W)
) u_pacer_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_active    (rd_active),
    .hold_req     (hold_req),
    .burst_pend_n (burst_pend_n),
    .fifo_empty   (fifo_empty),
    .trdy         (trdy),
    .fifo_pop     (fifo_pop),
    .disc_req     (disc_req),
    .wait_cnt     (wait_cnt),
    .proto_err    (proto_err)
);

// File: tb/rd_phase_pacer_tb_top.sv
// Directed bench for the read data phase pacer.
module rd_phase_pacer_tb_top;
    localparam int DEPTH = 8;
    localparam int MAXW  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_active = 1'b0;
    logic       hold_req = 1'b0;
    logic       burst_pend_n = 1'b0;
    logic       dly_rd_en = 1'b1;
    logic [3:0] lvl;
    logic       fifo_full, fifo_empty;
    logic       trdy, fifo_pop, disc_req;
    logic [3:0] wait_cnt;
    logic [1:0] proto_err;
    int         push_n = 0;
    int         n_chk = 0;
    int         n_err = 0;
    int         cyc_cnt = 0;

    always #10 clk = ~clk;

    rd_phase_pacer #(.FIFO_DEPTH(DEPTH), .MAX_WAIT(MAXW), .MIN_ASSERT(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_active(rd_active), .hold_req(hold_req),
        .burst_pend_n(burst_pend_n), .dly_rd_en(dly_rd_en),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_level(lvl),
        .trdy(trdy), .fifo_pop(fifo_pop), .disc_req(disc_req),
        .wait_cnt(wait_cnt), .proto_err(proto_err)
    );

    // Simple FIFO occupancy model
    assign fifo_empty = (lvl == 4'd0);
    assign fifo_full  = (lvl == 4'(DEPTH));
    always @(posedge clk) begin
        if (!rst_n) lvl <= 4'd0;
        else        lvl <= 4'(int'(lvl) + push_n - int'(fifo_pop));
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 20000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: act=%0d exp<=20000", cyc_cnt);
            report();
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk); #1;
    endtask

    task automatic end_xfer();
        rd_active = 1'b0; push_n = 0;
        cyc();
        check("R10 trdy after end", int'(trdy), 0);
        check("R10 disc after end", int'(disc_req), 0);
        cyc();
    endtask

    task automatic t_reset();
        rd_active = 1'b1;
        repeat (3) cyc();
        check("R1 trdy", int'(trdy), 0);
        check("R1 disc", int'(disc_req), 0);
        check("R1 pop", int'(fifo_pop), 0);
        check("R1 wait", int'(wait_cnt), 0);
        check("R1 proto", int'(proto_err), 0);
        rd_active = 1'b0;
        rst_n = 1'b1;
        repeat (2) cyc();
        check("R1 idle trdy", int'(trdy), 0);
    endtask

    // Hold delays start, then burst timeout after eight empty cycles
    task automatic t_hold_then_timeout();
        burst_pend_n = 1'b0; hold_req = 1'b1; push_n = 3; rd_active = 1'b1;
        cyc(); push_n = 0;
        for (int i = 0; i < 4; i++) begin
            check("R2 held", int'(trdy), 0);
            cyc();
        end
        hold_req = 1'b0;
        cyc();
        check("R2 first trdy", int'(trdy), 1);
        check("R5 pop", int'(fifo_pop), 1);
        cyc(); cyc();
        check("R5 third word", int'(trdy), 1);
        cyc();
        check("R5 empty no trdy", int'(trdy), 0);
        check("R6 wait cleared", int'(wait_cnt), 0);
        for (int k = 1; k < MAXW; k++) begin
            cyc();
            check("R6 wait count", int'(wait_cnt), k);
            check("R7 no early disc", int'(disc_req), 0);
        end
        cyc();
        check("R7 wait sat", int'(wait_cnt), MAXW);
        check("R7 disc", int'(disc_req), 1);
        cyc();
        check("R7 wait held", int'(wait_cnt), MAXW);
        end_xfer();
    endtask

    // Refill before the limit resumes data phases
    task automatic t_refill();
        burst_pend_n = 1'b0; hold_req = 1'b0; push_n = 1; rd_active = 1'b1;
        cyc(); push_n = 0;
        cyc();
        check("R6 trdy", int'(trdy), 1);
        cyc(); cyc(); cyc(); cyc();
        check("R6 wait 3", int'(wait_cnt), 3);
        push_n = 1;
        cyc(); push_n = 0;
        check("R6 resumed trdy", int'(trdy), 1);
        check("R6 wait 4", int'(wait_cnt), 4);
        cyc();
        check("R6 wait reset", int'(wait_cnt), 0);
        check("R6 no disc", int'(disc_req), 0);
        end_xfer();
    endtask

    // Full FIFO overrides hold; hold ignored afterwards
    task automatic t_full_release();
        int seen;
        burst_pend_n = 1'b0; hold_req = 1'b1; rd_active = 1'b1; push_n = 1;
        for (int i = 0; i < DEPTH; i++) begin
            cyc();
            check("R3 held until full", int'(trdy), 0);
        end
        push_n = 0;
        cyc();
        check("R3 full release", int'(trdy), 1);
        seen = 1;
        for (int i = 0; i < DEPTH; i++) begin
            cyc();
            if (trdy) seen++;
        end
        check("R4 all words with hold high", seen, DEPTH);
        hold_req = 1'b0;
        end_xfer();
    endtask

    // Immediate disconnect, hold-off of new data, restart with hold
    task automatic t_immediate_disc();
        burst_pend_n = 1'b1; dly_rd_en = 1'b1; hold_req = 1'b0;
        push_n = 2; rd_active = 1'b1;
        cyc(); push_n = 0;
        cyc();
        check("R8 trdy", int'(trdy), 1);
        cyc();
        cyc();
        check("R8 no disc yet", int'(disc_req), 0);
        cyc();
        check("R8 disc", int'(disc_req), 1);
        check("R8 wait zero", int'(wait_cnt), 0);
        push_n = 1;
        cyc(); push_n = 0;
        check("R10 disc held", int'(disc_req), 1);
        cyc();
        check("R10 no trdy in disc", int'(trdy), 0);
        end_xfer();
        hold_req = 1'b1; rd_active = 1'b1;
        repeat (3) cyc();
        check("R11 hold applied again", int'(trdy), 0);
        hold_req = 1'b0;
        cyc();
        check("R11 start after release", int'(trdy), 1);
        end_xfer();
    endtask

    // Delayed-read enable low forces burst mode
    task automatic t_dly_forces_burst();
        dly_rd_en = 1'b0; burst_pend_n = 1'b1; hold_req = 1'b0;
        push_n = 1; rd_active = 1'b1;
        cyc(); push_n = 0;
        cyc();
        check("R9 trdy", int'(trdy), 1);
        cyc(); cyc();
        check("R9 no immediate disc", int'(disc_req), 0);
        check("R9 counting", int'(wait_cnt), 1);
        repeat (MAXW - 1) cyc();
        check("R9 timeout disc", int'(disc_req), 1);
        end_xfer();
        dly_rd_en = 1'b1;
    endtask

    // Short assertions of the controls are flagged
    task automatic t_proto();
        hold_req = 1'b1;
        cyc();
        hold_req = 1'b0; #1;
        check("R12 short hold", int'(proto_err), 1);
        cyc();
        check("R12 flag clears", int'(proto_err), 0);
        hold_req = 1'b1;
        cyc(); cyc();
        hold_req = 1'b0; #1;
        check("R12 long hold ok", int'(proto_err), 0);
        cyc(); cyc();
        burst_pend_n = 1'b0;
        cyc();
        burst_pend_n = 1'b1; #1;
        check("R12 short burst", int'(proto_err), 2);
        cyc();
    endtask

    initial begin
        t_reset();
        t_hold_then_timeout();
        t_refill();
        t_full_release();
        t_immediate_disc();
        t_dly_forces_burst();
        t_proto();
        report();
        $finish;
    end

endmodule